// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog Reset

This block keeps a 32-bit up-counter that advances by one on every clock cycle in which an external tick strobe is high. Four compare channels each hold a 32-bit target. When the counter takes on a channel's target value and that channel is enabled, the channel latches a sticky status flag and drives its own interrupt line. Software acknowledges an interrupt by writing a one to the matching status bit.

Channel 3 also serves as a watchdog. If the watchdog arm bit is set when channel 3 matches, the block emits a one-cycle reset-request pulse and disarms itself. Software reaches every register through a flat 32-bit register port. A write takes effect at the next clock edge, and a read returns data combinationally from the presented address.

The tick strobe is generated outside the block, and the bus-protocol adapter sits outside it too.

Top module: `match_timer4`

## Requirements
- R1: After reset, the counter, all four targets, the status flags, the interrupt-enable register and the watchdog register read 0, `irq` is 0000 and `rst_req` is 0.
- R2: The register offsets are: target of channel n at 4*n (0x00, 0x04, 0x08, 0x0C), counter at 0x10, status at 0x14, watchdog at 0x18 and interrupt enable at 0x1C. Each target, the counter and the watchdog register read back the last full 32-bit value written to them.
- R3: The counter adds one, modulo 2^32, at each clock edge where `tick_en` is 1. It holds its value when `tick_en` is 0.
- R4: A write to the counter loads the written value, and the write takes priority over a tick in the same cycle. Counting then continues from the loaded value, and a loaded value equal to an enabled target counts as a match.
- R5: A match occurs at the edge where the counter takes a new value equal to target n. If interrupt-enable bit n is 1, status bit n becomes 1 and `irq[n]` goes high on that same edge, and both stay high until cleared.
- R6: If interrupt-enable bit n is 0 when channel n matches, status bit n and `irq[n]` do not change.
- R7: A write to status clears exactly the bits written as 1, and `irq[n]` falls together with status bit n. Bits written as 0 are left unchanged. Status occupies bits 3:0 and reads 0 above them.
- R8: The interrupt-enable register holds bits 11:0. Bit n enables channel n. Written bits above bit 11 are dropped and read back as 0.
- R9: If watchdog bit 0 is 1 when channel 3 matches, `rst_req` is high for exactly one cycle, starting at the match edge, and the watchdog register is cleared on that edge. This does not depend on interrupt enable. With bit 0 clear, no request is made.
- R10: Matching is by equality only. A target of 0 matches when the counter wraps from 0xFFFFFFFF to 0.
- R11: A match is detected only when the counter changes value. Holding the counter, or writing a target equal to the present count, raises nothing.
- R12: Reads of any other offset, including unaligned ones, return 0. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-advance strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 4 | Per-channel interrupt lines |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The bench steps the counter onto each target one tick at a time. A design that compared against the old count would flag a match one tick late, and a design that compared continuously would keep re-raising a flag the software had already cleared while the counter sat still. It also clears one flag out of two, which exposes a clear that wipes the whole status word, and it wraps the counter onto a target of zero, which exposes a magnitude compare. Finally, it fires the watchdog with channel 3's interrupt disabled and then matches again. A watchdog gated by the interrupt enable would stay silent on the first match, and one that fails to disarm itself would fire a second time.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int OFS_COUNT  = 'h10;
  localparam int OFS_STATUS = 'h14;
  localparam int OFS_WDOG   = 'h18;
  localparam int OFS_IEN    = 'h1C;
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] cnt_nxt,
  output logic          cnt_upd
);
  always_comb begin
    cnt_upd = load | tick_en;
    if (load)         cnt_nxt = load_val;
    else if (tick_en) cnt_nxt = cnt_q + DW'(1);
    else              cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_upd) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/mt_match_bank.sv
module mt_match_bank #(
  parameter int DW  = 32,
  parameter int NCH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          we,
  input  logic [DW-1:0]           wdata,
  input  logic [DW-1:0]           cnt_nxt,
  input  logic                    cnt_upd,
  output logic [NCH-1:0][DW-1:0]  tgt_q,
  output logic [NCH-1:0]          hit
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] tgt_nxt;
    always_comb begin
      tgt_nxt = we[g] ? wdata : tgt_q[g];
      hit[g]  = cnt_upd && (cnt_nxt == tgt_q[g]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgt_q[g] <= '0;
      else        tgt_q[g] <= tgt_nxt;
    end
  end
endmodule

// File: rtl/match_timer4.sv
module match_timer4 #(
  parameter int DW  = 32,
  parameter int AW  = 8,
  parameter int NCH = 4,
  parameter int IEW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [NCH-1:0] irq,
  output logic          rst_req
);
  import mt_pkg::*;
  localparam int WD_CH = NCH - 1;

  logic [NCH-1:0]         tgt_we;
  logic [NCH-1:0]         tgt_sel;
  logic                   sel_cnt, sel_st, sel_wd, sel_ie;
  logic                   cnt_ld;
  logic [DW-1:0]          cnt_q, cnt_nxt;
  logic                   cnt_upd;
  logic [NCH-1:0][DW-1:0] tgt_q;
  logic [NCH-1:0]         hit;
  logic [NCH-1:0]         st_q, st_nxt, st_set, st_clr;
  logic [IEW-1:0]         ie_q, ie_nxt;
  logic [DW-1:0]          wd_q, wd_nxt;
  logic                   fire;

  // address decode
  always_comb begin
    sel_cnt = (reg_addr == AW'(OFS_COUNT));
    sel_st  = (reg_addr == AW'(OFS_STATUS));
    sel_wd  = (reg_addr == AW'(OFS_WDOG));
    sel_ie  = (reg_addr == AW'(OFS_IEN));
    for (int i = 0; i < NCH; i++) begin
      tgt_sel[i] = (reg_addr == AW'(4 * i));
      tgt_we[i]  = reg_wr && tgt_sel[i];
    end
    cnt_ld = reg_wr && sel_cnt;
  end

  mt_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .load(cnt_ld), .load_val(reg_wdata),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .cnt_upd(cnt_upd)
  );

  mt_match_bank #(.DW(DW), .NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(tgt_we), .wdata(reg_wdata),
    .cnt_nxt(cnt_nxt), .cnt_upd(cnt_upd), .tgt_q(tgt_q), .hit(hit)
  );

  // next state: status, enable, watchdog
  always_comb begin
    st_set = hit & ie_q[NCH-1:0];
    st_clr = (reg_wr && sel_st) ? reg_wdata[NCH-1:0] : '0;
    st_nxt = (st_q & ~st_clr) | st_set;
    ie_nxt = (reg_wr && sel_ie) ? reg_wdata[IEW-1:0] : ie_q;
    fire   = hit[WD_CH] && wd_q[0];
    if (fire)                  wd_nxt = '0;
    else if (reg_wr && sel_wd) wd_nxt = reg_wdata;
    else                       wd_nxt = wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      ie_q    <= '0;
      wd_q    <= '0;
      rst_req <= 1'b0;
    end else begin
      st_q    <= st_nxt;
      ie_q    <= ie_nxt;
      wd_q    <= wd_nxt;
      rst_req <= fire;
    end
  end

  assign irq = st_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (sel_cnt)     reg_rdata = cnt_q;
    else if (sel_st) reg_rdata = DW'(st_q);
    else if (sel_wd) reg_rdata = wd_q;
    else if (sel_ie) reg_rdata = DW'(ie_q);
    else begin
      for (int i = 0; i < NCH; i++)
        if (tgt_sel[i]) reg_rdata = tgt_q[i];
    end
  end
endmodule

// File: rtl/match_timer4_chk.sv
module match_timer4_chk #(
  parameter int DW  = 32,
  parameter int AW  = 8,
  parameter int NCH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick_en,
  input logic                   cnt_ld,
  input logic [DW-1:0]          cnt_q,
  input logic [NCH-1:0][DW-1:0] tgt_q,
  input logic [NCH-1:0]         irq,
  input logic                   rst_req,
  input logic [DW-1:0]          wd_q,
  input logic [AW-1:0]          reg_addr,
  input logic [DW-1:0]          reg_rdata
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !cnt_ld |=> cnt_q == $past(cnt_q) + DW'(1)); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !cnt_ld |=> $stable(cnt_q)); // R3
  AST_WD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R9
  AST_WD_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> wd_q == '0); // R9
  AST_IEN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == AW'('h1C) |-> reg_rdata[DW-1:12] == '0); // R8
  for (genvar g = 0; g < NCH; g++) begin : g_a
    AST_IRQ_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[g]) |-> cnt_q == tgt_q[g]); // R5
  end
endmodule

bind match_timer4 match_timer4_chk #(.DW(DW), .AW(AW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_ld(cnt_ld),
  .cnt_q(cnt_q), .tgt_q(tgt_q), .irq(irq), .rst_req(rst_req),
  .wd_q(wd_q), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/tb_match_timer4.sv
`timescale 1ns/1ps
module tb_match_timer4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq;
  logic        rst_req;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  match_timer4 dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  task automatic tick(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 'h20; a += 4) rd_chk(8'(a), 32'h0, "R1");
    chk(irq === 4'h0, "R1", 32'(irq), 32'h0);
    chk(rst_req === 1'b0, "R1", 32'(rst_req), 32'h0);
  endtask

  task automatic t_map;
    for (int i = 0; i < 4; i++) wr(8'(4 * i), 32'hA000_0000 + 32'(i));
    wr(8'h10, 32'h1234_5678);
    wr(8'h18, 32'h0000_00F0);
    for (int i = 0; i < 4; i++) rd_chk(8'(4 * i), 32'hA000_0000 + 32'(i), "R2");
    rd_chk(8'h10, 32'h1234_5678, "R2");
    rd_chk(8'h18, 32'h0000_00F0, "R2");
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd_chk(8'h24, 32'h0, "R12");
    rd_chk(8'h01, 32'h0, "R12");
    rd_chk(8'h00, 32'hA000_0000, "R12");
    rd_chk(8'h10, 32'h1234_5678, "R12");
    wr(8'h18, 32'h0);
  endtask

  task automatic t_count;
    wr(8'h10, 32'd100);
    tick(5);
    rd_chk(8'h10, 32'd105, "R3");
    repeat (3) @(negedge clk);
    rd_chk(8'h10, 32'd105, "R3");
    tick_en = 1'b1;
    wr(8'h10, 32'd500);
    tick_en = 1'b0;
    rd_chk(8'h10, 32'd500, "R4");
    tick(2);
    rd_chk(8'h10, 32'd502, "R4");
  endtask

  task automatic t_match;
    wr(8'h1C, 32'h1);
    wr(8'h00, 32'h200);
    wr(8'h10, 32'h1FE);
    tick(1);
    chk(irq === 4'h0, "R5", 32'(irq), 32'h0);
    tick(1);
    chk(irq === 4'h1, "R5", 32'(irq), 32'h1);
    rd_chk(8'h14, 32'h1, "R5");
    wr(8'h14, 32'h1);
    repeat (4) @(negedge clk);
    chk(irq === 4'h0, "R11", 32'(irq), 32'h0);
    wr(8'h00, 32'h200);
    @(negedge clk);
    chk(irq === 4'h0, "R11", 32'(irq), 32'h0);
    wr(8'h00, 32'h555);
    wr(8'h10, 32'h555);
    chk(irq === 4'h1, "R4", 32'(irq), 32'h1);
    wr(8'h14, 32'hF);
  endtask

  task automatic t_w1c;
    wr(8'h1C, 32'h3);
    wr(8'h00, 32'h300);
    wr(8'h04, 32'h301);
    wr(8'h10, 32'h2FF);
    tick(2);
    chk(irq === 4'h3, "R7", 32'(irq), 32'h3);
    wr(8'h14, 32'h2);
    chk(irq === 4'h1, "R7", 32'(irq), 32'h1);
    wr(8'h14, 32'h0);
    rd_chk(8'h14, 32'h1, "R7");
    wr(8'h14, 32'hFFFF_FFF1);
    rd_chk(8'h14, 32'h0, "R7");
    chk(irq === 4'h0, "R7", 32'(irq), 32'h0);
  endtask

  task automatic t_disabled;
    wr(8'h1C, 32'h1);
    wr(8'h08, 32'h400);
    wr(8'h10, 32'h3FF);
    tick(1);
    chk(irq === 4'h0, "R6", 32'(irq), 32'h0);
    rd_chk(8'h14, 32'h0, "R6");
  endtask

  task automatic t_ien;
    wr(8'h1C, 32'hFFFF_FFFF);
    rd_chk(8'h1C, 32'h0000_0FFF, "R8");
    wr(8'h1C, 32'h0);
  endtask

  task automatic t_wrap;
    wr(8'h1C, 32'h2);
    wr(8'h04, 32'h0);
    wr(8'h10, 32'hFFFF_FFFE);
    tick(1);
    chk(irq === 4'h0, "R10", 32'(irq), 32'h0);
    tick(1);
    rd_chk(8'h10, 32'h0, "R10");
    chk(irq === 4'h2, "R10", 32'(irq), 32'h2);
    wr(8'h14, 32'hF);
    wr(8'h1C, 32'h0);
  endtask

  task automatic t_wdog;
    wr(8'h18, 32'h1);
    wr(8'h0C, 32'h700);
    wr(8'h10, 32'h6FF);
    tick(1);
    chk(rst_req === 1'b1, "R9", 32'(rst_req), 32'h1);
    rd_chk(8'h18, 32'h0, "R9");
    chk(irq === 4'h0, "R9", 32'(irq), 32'h0);
    @(negedge clk);
    chk(rst_req === 1'b0, "R9", 32'(rst_req), 32'h0);
    wr(8'h10, 32'h6FF);
    tick(1);
    chk(rst_req === 1'b0, "R9", 32'(rst_req), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_count();
    t_match();
    t_w1c();
    t_disabled();
    t_ien();
    t_wrap();
    t_wdog();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_err);
    $finish;
  end
endmodule